// File: doc/BRIEF.md
# Burst-Aware Slave Port Arbiter

This block decides which of several bus masters owns one slave port of a multi-master interconnect. Every slave port gets its own copy, so contention is settled per slave. Each cycle the block sees the masters' request lines and the status of the transfer now on the port: transfer type, whether the access is a single or a burst, whether the burst has a fixed or an undefined length, a last-beat flag for fixed bursts, and a predicted end-of-burst pulse for undefined bursts. It outputs a registered one-hot grant and the index of the owning master.

The owner may change only at a safe point. The safe points are an idle cycle, a single access, the final beat of a burst, or the moment a per-grant slot counter reaches its configured limit. At a safe point the next owner is chosen by round-robin or by programmed fixed priority. If nobody is requesting, the port parks on a configurable default master. All configuration arrives on static input pins. There is no data stream here, so every pin is a plain control or status signal and no valid/ready handshake or back-pressure applies.

Top module: `slave_arbiter`

## Requirements
- R1: While reset is asserted, owner is 0 and grant is one-hot with bit 0 set.
- R2: At all times grant has exactly one bit set, and that bit is the one indexed by owner.
- R3: Owner and grant change only on the clock edge that follows a cycle that was a safe point. During a burst that is neither ending nor over its slot limit, the grant holds even while other masters request.
- R4: A cycle whose transfer type is IDLE (encoding 2'b00; BUSY=01, NONSEQ=10, SEQ=11) is a safe point.
- R5: A cycle with a non-idle transfer and burst_single=1 is a safe point.
- R6: For a fixed-length burst (burst_single=0, burst_undef=0), a non-idle cycle with last_beat=1 is a safe point.
- R7: For an undefined-length burst (burst_undef=1), a non-idle cycle with eob_pred=1 is a safe point, and last_beat has no effect.
- R8: The slot counter clears at every safe point and otherwise counts non-idle cycles. A cycle where slot_limit is non-zero and the counter has reached slot_limit is a safe point, so a burst with no end mark is broken after slot_limit+1 cycles. A slot_limit of 0 disables this check.
- R9: With fixed_mode=0 (round-robin), the next owner is the first requester found searching from owner+1 upward, wrapping past the highest index. The current owner is chosen again only when no other master is requesting.
- R10: With fixed_mode=1, the requester with the largest priority field wins, and ties go to the lowest index. Master i's priority is prio[i*PRIO_W +: PRIO_W].
- R11: At a safe point with no request pending, the owner becomes def_master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_M | Request line of each master |
| xfer_type | input | 2 | Type of the current transfer on the port (IDLE/BUSY/NONSEQ/SEQ) |
| burst_single | input | 1 | Current access is a single transfer |
| burst_undef | input | 1 | Current burst has undefined length |
| last_beat | input | 1 | Final beat of a fixed-length burst |
| eob_pred | input | 1 | Predicted end-of-burst pulse for undefined-length bursts |
| fixed_mode | input | 1 | 0 selects round-robin, 1 selects fixed priority |
| prio | input | NUM_M*PRIO_W | Packed priority field per master |
| def_master | input | IDX_W | Master the port parks on when there are no requests |
| slot_limit | input | SLOT_W | Slot cycle limit; 0 disables it |
| grant | output | NUM_M | Registered one-hot grant |
| owner | output | IDX_W | Registered index of the owning master |

## Verification
Round-robin is driven with a sparse request mask that is held steady over several idle cycles. This shows that the search starts after the owner and wraps, rather than restarting at index 0. Fixed priority is driven with equal top priorities and then with masks where a lower index has the lower priority, which separates "largest value" from "lowest index". Bursts run with competing requests, and the bench flips last_beat, eob_pred and the burst kind to show which mark closes each burst kind. A long unterminated burst with a slot limit of 3 and then 0 pins down the exact cycle of the forced break and that a zero limit turns it off.

// File: rtl/slave_arbiter_pkg.sv
`timescale 1ns/1ps
package slave_arbiter_pkg;
  typedef enum logic [1:0] {
    XF_IDLE   = 2'b00,
    XF_BUSY   = 2'b01,
    XF_NONSEQ = 2'b10,
    XF_SEQ    = 2'b11
  } xfer_e;
endpackage

// File: rtl/arb_point_detect.sv
`timescale 1ns/1ps
module arb_point_detect
  import slave_arbiter_pkg::*;
(
  input  logic [1:0] xfer_type,
  input  logic       burst_single,
  input  logic       burst_undef,
  input  logic       last_beat,
  input  logic       eob_pred,
  input  logic       slot_hit,
  output logic       active,
  output logic       arb_pt
);
  logic idle_pt, single_pt, end_pt;

  always_comb begin
    active    = (xfer_e'(xfer_type) != XF_IDLE);
    idle_pt   = !active;
    single_pt = active && burst_single;
    end_pt    = active && !burst_single && (burst_undef ? eob_pred : last_beat);
    arb_pt    = idle_pt || single_pt || end_pt || slot_hit;
  end
endmodule

// File: rtl/slot_counter.sv
`timescale 1ns/1ps
module slot_counter #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              arb_pt,
  input  logic [SLOT_W-1:0] limit,
  output logic [SLOT_W-1:0] count,
  output logic              slot_hit
);
  localparam logic [SLOT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       count <= '0;
    else if (arb_pt)                  count <= '0;
    else if (active && count != CNT_MAX) count <= count + 1'b1;
  end

  assign slot_hit = (limit != '0) && (count >= limit);
endmodule

// File: rtl/owner_select.sv
`timescale 1ns/1ps
module owner_select #(
  parameter int NUM_M  = 4,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_M-1:0]        req,
  input  logic [IDX_W-1:0]        owner,
  input  logic                    fixed_mode,
  input  logic [NUM_M*PRIO_W-1:0] prio,
  input  logic [IDX_W-1:0]        def_master,
  output logic [IDX_W-1:0]        next_owner
);
  logic [IDX_W-1:0]  rr_sel, fp_sel;
  logic              rr_hit, fp_hit;
  logic [PRIO_W-1:0] fp_best;

  always_comb begin
    rr_sel = def_master;
    rr_hit = 1'b0;
    for (int k = 1; k <= NUM_M; k++) begin
      if (!rr_hit && req[(int'(owner) + k) % NUM_M]) begin
        rr_hit = 1'b1;
        rr_sel = IDX_W'((int'(owner) + k) % NUM_M);
      end
    end
  end

  always_comb begin
    fp_sel  = def_master;
    fp_hit  = 1'b0;
    fp_best = '0;
    for (int i = 0; i < NUM_M; i++) begin
      if (req[i] && (!fp_hit || prio[i*PRIO_W +: PRIO_W] > fp_best)) begin
        fp_hit  = 1'b1;
        fp_best = prio[i*PRIO_W +: PRIO_W];
        fp_sel  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (req == '0)       next_owner = def_master;
    else if (fixed_mode) next_owner = fp_sel;
    else                 next_owner = rr_sel;
  end
endmodule

// File: rtl/slave_arbiter.sv
`timescale 1ns/1ps
module slave_arbiter #(
  parameter int NUM_M  = 4,
  parameter int PRIO_W = 2,
  parameter int SLOT_W = 8,
  localparam int IDX_W = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_M-1:0]        req,
  input  logic [1:0]              xfer_type,
  input  logic                    burst_single,
  input  logic                    burst_undef,
  input  logic                    last_beat,
  input  logic                    eob_pred,
  input  logic                    fixed_mode,
  input  logic [NUM_M*PRIO_W-1:0] prio,
  input  logic [IDX_W-1:0]        def_master,
  input  logic [SLOT_W-1:0]       slot_limit,
  output logic [NUM_M-1:0]        grant,
  output logic [IDX_W-1:0]        owner
);
  logic              active, arb_pt, slot_hit;
  logic [SLOT_W-1:0] slot_cnt;
  logic [IDX_W-1:0]  next_owner;
  logic [IDX_W-1:0]  owner_q;
  logic [NUM_M-1:0]  grant_q;

  arb_point_detect u_point (
    .xfer_type    (xfer_type),
    .burst_single (burst_single),
    .burst_undef  (burst_undef),
    .last_beat    (last_beat),
    .eob_pred     (eob_pred),
    .slot_hit     (slot_hit),
    .active       (active),
    .arb_pt       (arb_pt)
  );

  slot_counter #(.SLOT_W(SLOT_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .arb_pt   (arb_pt),
    .limit    (slot_limit),
    .count    (slot_cnt),
    .slot_hit (slot_hit)
  );

  owner_select #(.NUM_M(NUM_M), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sel (
    .req        (req),
    .owner      (owner_q),
    .fixed_mode (fixed_mode),
    .prio       (prio),
    .def_master (def_master),
    .next_owner (next_owner)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      grant_q <= NUM_M'(1);
    end else if (arb_pt) begin
      owner_q <= next_owner;
      grant_q <= NUM_M'(1) << next_owner;
    end
  end

  assign owner = owner_q;
  assign grant = grant_q;
endmodule

// File: rtl/slave_arbiter_chk.sv
`timescale 1ns/1ps
module slave_arbiter_chk #(
  parameter int NUM_M  = 4,
  parameter int SLOT_W = 8,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_M-1:0]  req,
  input logic [1:0]        xfer_type,
  input logic [IDX_W-1:0]  def_master,
  input logic [SLOT_W-1:0] slot_limit,
  input logic [NUM_M-1:0]  grant,
  input logic [IDX_W-1:0]  owner,
  input logic              arb_pt,
  input logic [SLOT_W-1:0] slot_cnt
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1); // R2

  AST_GRANT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    grant[owner] == 1'b1); // R2

  AST_HOLD_OFF_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_pt |=> ($stable(owner) && $stable(grant))); // R3

  AST_IDLE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_type == 2'b00 && req == '0) |=> owner == $past(def_master)); // R11

  AST_SLOT_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_limit != '0 && slot_cnt >= slot_limit) |-> arb_pt); // R8

  AST_IDLE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_type == 2'b00) |-> arb_pt); // R4
endmodule

bind slave_arbiter slave_arbiter_chk #(
  .NUM_M (NUM_M),
  .SLOT_W(SLOT_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .xfer_type  (xfer_type),
  .def_master (def_master),
  .slot_limit (slot_limit),
  .grant      (grant),
  .owner      (owner),
  .arb_pt     (arb_pt),
  .slot_cnt   (slot_cnt)
);

// File: tb/slave_arbiter_bench.sv
`timescale 1ns/1ps
module slave_arbiter_bench;
  localparam int NUM_M = 4, PRIO_W = 2, SLOT_W = 8, IDX_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_M-1:0] req = '0;
  logic [1:0] xfer_type = 2'b00;
  logic burst_single = 1'b0, burst_undef = 1'b0, last_beat = 1'b0, eob_pred = 1'b0;
  logic fixed_mode = 1'b0;
  logic [NUM_M*PRIO_W-1:0] prio = '0;
  logic [IDX_W-1:0] def_master = '0;
  logic [SLOT_W-1:0] slot_limit = '0;
  logic [NUM_M-1:0] grant;
  logic [IDX_W-1:0] owner;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  slave_arbiter #(.NUM_M(NUM_M), .PRIO_W(PRIO_W), .SLOT_W(SLOT_W)) u_slave_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .xfer_type(xfer_type),
    .burst_single(burst_single), .burst_undef(burst_undef),
    .last_beat(last_beat), .eob_pred(eob_pred), .fixed_mode(fixed_mode),
    .prio(prio), .def_master(def_master), .slot_limit(slot_limit),
    .grant(grant), .owner(owner)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_owner(input string tag, input int exp);
    logic [NUM_M-1:0] eg;
    eg = NUM_M'(1) << exp;
    checks++;
    if (int'(owner) != exp || grant != eg) begin
      errors++;
      $display("FAIL %s: owner=%0d grant=%b expected owner=%0d grant=%b",
               tag, owner, grant, exp, eg);
    end
  endtask

  task automatic drive(input logic [1:0] t, input logic sg, input logic un,
                       input logic lb, input logic ep);
    xfer_type = t; burst_single = sg; burst_undef = un; last_beat = lb; eob_pred = ep;
  endtask

  task automatic t_reset();
    #3;
    expect_owner("R1 reset state", 0);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_default();
    def_master = 2'd2; req = '0; drive(2'b00, 0, 0, 0, 0);
    step(); expect_owner("R11/R4 park on default", 2);
  endtask

  task automatic t_round_robin();
    req = 4'b1011;
    step(); expect_owner("R9 after 2", 3);
    step(); expect_owner("R9 wrap after 3", 0);
    step(); expect_owner("R9 after 0", 1);
    step(); expect_owner("R9 skip 2", 3);
  endtask

  task automatic t_fixed_burst();
    req = 4'b0001; step(); expect_owner("R9 lone requester", 0);
    req = 4'b0011; drive(2'b10, 0, 0, 0, 0);
    step(); expect_owner("R3 burst first beat holds", 0);
    drive(2'b11, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step(); expect_owner("R3 burst mid beat holds", 0);
    end
    drive(2'b01, 0, 0, 0, 0);
    step(); expect_owner("R3 busy beat holds", 0);
    drive(2'b11, 0, 0, 1, 0);
    step(); expect_owner("R6 last beat hands over", 1);
  endtask

  task automatic t_single();
    req = 4'b0101; drive(2'b10, 1, 0, 0, 0);
    step(); expect_owner("R5 single access arbitrates", 2);
  endtask

  task automatic t_undef_burst();
    req = 4'b0001; drive(2'b00, 0, 0, 0, 0);
    step(); expect_owner("R9 setup", 0);
    req = 4'b0011; drive(2'b10, 0, 1, 1, 0);
    step(); expect_owner("R7 last_beat ignored", 0);
    drive(2'b11, 0, 1, 0, 1);
    step(); expect_owner("R7 predicted end hands over", 1);
  endtask

  task automatic t_slot();
    slot_limit = 8'd3;
    req = 4'b0001; drive(2'b00, 0, 0, 0, 0);
    step(); expect_owner("R8 setup", 0);
    req = 4'b0011; drive(2'b10, 0, 0, 0, 0);
    step(); expect_owner("R8 count 0", 0);
    drive(2'b11, 0, 0, 0, 0);
    step(); expect_owner("R8 count 1", 0);
    step(); expect_owner("R8 count 2", 0);
    step(); expect_owner("R8 limit breaks burst", 1);
    slot_limit = 8'd0;
    req = 4'b0001; drive(2'b00, 0, 0, 0, 0);
    step(); expect_owner("R8 setup disabled", 0);
    req = 4'b0011; drive(2'b10, 0, 0, 0, 0);
    step();
    drive(2'b11, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) step();
    expect_owner("R8 zero limit never breaks", 0);
  endtask

  task automatic t_fixed_prio();
    fixed_mode = 1'b1;
    prio = {2'd2, 2'd3, 2'd3, 2'd1};
    req = 4'b1111; drive(2'b00, 0, 0, 0, 0);
    step(); expect_owner("R10 tie to lower index", 1);
    step(); expect_owner("R10 no rotation", 1);
    req = 4'b1001;
    step(); expect_owner("R10 higher value beats lower index", 3);
    req = 4'b0101;
    step(); expect_owner("R10 pick top value", 2);
    req = 4'b0000; def_master = 2'd3;
    step(); expect_owner("R11 park in fixed mode", 3);
  endtask

  initial begin
    t_reset();
    t_default();
    t_round_robin();
    t_fixed_burst();
    t_single();
    t_undef_burst();
    t_slot();
    t_fixed_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule